// File: doc/BRIEF.md
# Still-Image Display Override Address Generator

This block generates the frame-store read addresses, one pair per display line, that a video display controller uses to fetch picture data. Normally it reads from the luma and chroma buffers that the decoder names. When the host turns on override, it reads instead from a still image that the host has placed in memory, at start addresses the host supplies. The still frame can be shown in two ways. In field-repeat mode one stored field is shown in both display fields. In frame mode the stored fields are interleaved.

The host sets a picture width in units of 8 pixels, which fixes the line stride. A separate count sets how many reads go out per line, so a window narrower than the stored frame can be shown. All host settings are copied into shadow registers only when a field starts, so the host can write them at any time. A decode-request pulse goes out at each field start while the decoder is running and not frozen. This pulse does not depend on override, so decoding can continue behind a still picture.

Top module: `still_disp_addr`

## Requirements
- R1: After reset, `luma_addr`, `chroma_addr` and `line_reads` are zero, and `addr_valid` and `dec_req` are low.
- R2: `field_start` clears the line index k to 0. Each `line_start` that does not coincide with `field_start` produces addresses for the current k, raises `addr_valid` for exactly the following cycle, and then advances k by one. `addr_valid` is low in every other cycle.
- R3: With override latched on, `luma_addr` = override luma base + (2k+p) × stride (mod 2^ADDR_W), where stride = latched width × 8 bytes.
- R4: A latched width of 0 gives a stride of 8 bytes, the same as a width of 1.
- R5: `chroma_addr` = chroma base + (2·floor(k/2)+p) × stride, using the same base source and parity as luma (4:2:0 default).
- R6: In field-repeat mode (`field_mode`=1) with override on, p = 0 if `top_first`=1 and p = 1 otherwise, whatever the parity of the display field.
- R7: In frame mode (`field_mode`=0) with override on, p = `field_par` XOR NOT `top_first`. Here `field_par`=0 means the top display field.
- R8: With override latched off, the addresses use the decoder bases `dec_luma_base` and `dec_chroma_base`, and p = `field_par`.
- R9: `line_reads` equals the `reads_per_line` value latched at the last field start, whatever the width setting, and changes only in the cycle after a line strobe.
- R10: Changes to host settings made during a field have no effect on the addresses until the next `field_start`.
- R11: `dec_req` is high for one cycle, the cycle after `field_start`, only if `dec_started`=1 and `freeze`=0 in that `field_start` cycle. It is unaffected by override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Display field boundary strobe |
| line_start | input | 1 | Display line strobe |
| field_par | input | 1 | Current display field parity, 0 = top |
| ovr_en | input | 1 | Host: show still image |
| field_mode | input | 1 | Host: 1 = repeat one field, 0 = interleave both |
| top_first | input | 1 | Host: top field of the still image is first |
| ovr_luma_base | input | ADDR_W | Host: still-image luma start address |
| ovr_chroma_base | input | ADDR_W | Host: still-image chroma start address |
| pic_width | input | WIDTH_W | Host: picture width in 8-pixel units |
| reads_per_line | input | READS_W | Host: reads issued per line |
| dec_luma_base | input | ADDR_W | Decoder-selected luma buffer base |
| dec_chroma_base | input | ADDR_W | Decoder-selected chroma buffer base |
| dec_started | input | 1 | Decoder is running |
| freeze | input | 1 | Freeze active, suppresses decode requests |
| luma_addr | output | ADDR_W | Luma line start address |
| chroma_addr | output | ADDR_W | Chroma line start address |
| line_reads | output | READS_W | Reads to issue for this line |
| addr_valid | output | 1 | Addresses valid (one cycle after line strobe) |
| dec_req | output | 1 | Decode request pulse |

## Verification
A shadow register that held the wrong value would show up at the first line of the next field. Both addresses would be shifted by a whole multiple of the stride, or would come from the wrong base, and `line_reads` would be wrong. A line counter in the wrong state would shift each address by two strides per missed count, from the first `addr_valid` onward. A wrong parity selection would put luma off by exactly one stride. A fault in the decode-request gate would show in the very next cycle after a field strobe. The bench sweeps every mode, parity and field order against a set of widths over several lines, and checks each address against the formulas in the requirements.

// File: rtl/still_disp_pkg.sv
package still_disp_pkg;
   // Display override presentation mode.
   typedef enum logic {
      SD_FRAME = 1'b0,   // interleave both stored fields
      SD_FIELD = 1'b1    // repeat one stored field in both display fields
   } sd_mode_e;

   // Width unit is 8 pixels -> shift by 3 to get bytes.
   localparam int unsigned SD_UNIT_SHIFT = 3;

   // Source parity for the stored frame.
   function automatic logic sd_src_parity(input logic ovr,
                                          input sd_mode_e mode,
                                          input logic top_first,
                                          input logic disp_par);
      logic first_par;
      first_par = ~top_first;
      if (!ovr)
         return disp_par;
      else if (mode == SD_FIELD)
         return first_par;
      else
         return disp_par ^ first_par;
   endfunction
endpackage

// File: rtl/still_disp_shadow.sv
module still_disp_shadow
   import still_disp_pkg::*;
#(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned WIDTH_W  = 8,
   parameter int unsigned READS_W  = 8,
   localparam int unsigned STRIDE_W = WIDTH_W + SD_UNIT_SHIFT
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                field_start,
   input  logic                field_par,
   input  logic                ovr_en,
   input  logic                field_mode,
   input  logic                top_first,
   input  logic [ADDR_W-1:0]   ovr_luma_base,
   input  logic [ADDR_W-1:0]   ovr_chroma_base,
   input  logic [WIDTH_W-1:0]  pic_width,
   input  logic [READS_W-1:0]  reads_per_line,
   input  logic [ADDR_W-1:0]   dec_luma_base,
   input  logic [ADDR_W-1:0]   dec_chroma_base,
   output logic [ADDR_W-1:0]   sh_luma_base,
   output logic [ADDR_W-1:0]   sh_chroma_base,
   output logic [STRIDE_W-1:0] sh_stride,
   output logic [READS_W-1:0]  sh_reads,
   output logic                sh_parity
);
   logic [WIDTH_W-1:0] width_eff;
   logic               parity_nxt;
   sd_mode_e           mode_in;

   assign mode_in    = sd_mode_e'(field_mode);
   assign width_eff  = (pic_width == '0) ? WIDTH_W'(1) : pic_width;
   assign parity_nxt = sd_src_parity(ovr_en, mode_in, top_first, field_par);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_luma_base   <= '0;
         sh_chroma_base <= '0;
         sh_stride      <= '0;
         sh_reads       <= '0;
         sh_parity      <= 1'b0;
      end else if (field_start) begin
         sh_luma_base   <= ovr_en ? ovr_luma_base   : dec_luma_base;
         sh_chroma_base <= ovr_en ? ovr_chroma_base : dec_chroma_base;
         sh_stride      <= {width_eff, {SD_UNIT_SHIFT{1'b0}}};
         sh_reads       <= reads_per_line;
         sh_parity      <= parity_nxt;
      end
   end
endmodule

// File: rtl/still_disp_line_ctr.sv
module still_disp_line_ctr #(
   parameter int unsigned LINE_W = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              line_start,
   output logic [LINE_W-1:0] line_idx,
   output logic              line_go
);
   // A field strobe wins over a coincident line strobe.
   assign line_go = line_start & ~field_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_idx <= '0;
      else if (field_start)
         line_idx <= '0;
      else if (line_start)
         line_idx <= line_idx + LINE_W'(1);
   end
endmodule

// File: rtl/still_disp_addr_calc.sv
module still_disp_addr_calc #(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned STRIDE_W   = 11,
   parameter int unsigned READS_W    = 8,
   parameter int unsigned LINE_W     = 10,
   parameter bit          CHROMA_420 = 1'b1,
   localparam int unsigned ROW_W     = LINE_W + 1,
   localparam int unsigned PROD_W    = ROW_W + STRIDE_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_go,
   input  logic [LINE_W-1:0]   line_idx,
   input  logic                parity,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [ADDR_W-1:0]   luma_base,
   input  logic [ADDR_W-1:0]   chroma_base,
   input  logic [READS_W-1:0]  reads,
   output logic [ADDR_W-1:0]   luma_addr,
   output logic [ADDR_W-1:0]   chroma_addr,
   output logic [READS_W-1:0]  line_reads,
   output logic                addr_valid
);
   logic [ROW_W-1:0]  luma_row;
   logic [ROW_W-1:0]  chroma_row;
   logic [PROD_W-1:0] luma_off;
   logic [PROD_W-1:0] chroma_off;

   // Frame row of this field line: 2k + p.
   assign luma_row = {line_idx, parity};

   generate
      if (CHROMA_420) begin : g_c420
         // One chroma line per two luma lines in the field.
         assign chroma_row = {1'b0, line_idx[LINE_W-1:1], parity};
      end else begin : g_c422
         assign chroma_row = {line_idx, parity};
      end
   endgenerate

   assign luma_off   = PROD_W'(luma_row)   * PROD_W'(stride);
   assign chroma_off = PROD_W'(chroma_row) * PROD_W'(stride);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         luma_addr   <= '0;
         chroma_addr <= '0;
         line_reads  <= '0;
         addr_valid  <= 1'b0;
      end else begin
         addr_valid <= line_go;
         if (line_go) begin
            luma_addr   <= luma_base   + ADDR_W'(luma_off);
            chroma_addr <= chroma_base + ADDR_W'(chroma_off);
            line_reads  <= reads;
         end
      end
   end
endmodule

// File: rtl/still_disp_dec_gate.sv
module still_disp_dec_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic field_start,
   input  logic dec_started,
   input  logic freeze,
   output logic dec_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dec_req <= 1'b0;
      else
         dec_req <= field_start & dec_started & ~freeze;
   end
endmodule

// File: rtl/still_disp_addr.sv
module still_disp_addr
   import still_disp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned WIDTH_W    = 8,
   parameter int unsigned READS_W    = 8,
   parameter int unsigned LINE_W     = 10,
   parameter bit          CHROMA_420 = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               field_start,
   input  logic               line_start,
   input  logic               field_par,
   input  logic               ovr_en,
   input  logic               field_mode,
   input  logic               top_first,
   input  logic [ADDR_W-1:0]  ovr_luma_base,
   input  logic [ADDR_W-1:0]  ovr_chroma_base,
   input  logic [WIDTH_W-1:0] pic_width,
   input  logic [READS_W-1:0] reads_per_line,
   input  logic [ADDR_W-1:0]  dec_luma_base,
   input  logic [ADDR_W-1:0]  dec_chroma_base,
   input  logic               dec_started,
   input  logic               freeze,
   output logic [ADDR_W-1:0]  luma_addr,
   output logic [ADDR_W-1:0]  chroma_addr,
   output logic [READS_W-1:0] line_reads,
   output logic               addr_valid,
   output logic               dec_req
);
   localparam int unsigned STRIDE_W = WIDTH_W + SD_UNIT_SHIFT;
   localparam int unsigned PROD_W   = LINE_W + 1 + STRIDE_W;

   generate
      if (ADDR_W < PROD_W) begin : g_bad_addr_w
         $error("still_disp_addr: ADDR_W too narrow for LINE_W and WIDTH_W");
      end
      if (WIDTH_W < 1 || READS_W < 1 || LINE_W < 2) begin : g_bad_widths
         $error("still_disp_addr: WIDTH_W, READS_W must be >=1, LINE_W >=2");
      end
   endgenerate

   logic [ADDR_W-1:0]   sh_luma_base;
   logic [ADDR_W-1:0]   sh_chroma_base;
   logic [STRIDE_W-1:0] sh_stride;
   logic [READS_W-1:0]  sh_reads;
   logic                sh_parity;
   logic [LINE_W-1:0]   line_idx;
   logic                line_go;

   still_disp_shadow #(
      .ADDR_W  (ADDR_W),
      .WIDTH_W (WIDTH_W),
      .READS_W (READS_W)
   ) u_shadow (
      .clk             (clk),
      .rst_n           (rst_n),
      .field_start     (field_start),
      .field_par       (field_par),
      .ovr_en          (ovr_en),
      .field_mode      (field_mode),
      .top_first       (top_first),
      .ovr_luma_base   (ovr_luma_base),
      .ovr_chroma_base (ovr_chroma_base),
      .pic_width       (pic_width),
      .reads_per_line  (reads_per_line),
      .dec_luma_base   (dec_luma_base),
      .dec_chroma_base (dec_chroma_base),
      .sh_luma_base    (sh_luma_base),
      .sh_chroma_base  (sh_chroma_base),
      .sh_stride       (sh_stride),
      .sh_reads        (sh_reads),
      .sh_parity       (sh_parity)
   );

   still_disp_line_ctr #(
      .LINE_W (LINE_W)
   ) u_line_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .line_start  (line_start),
      .line_idx    (line_idx),
      .line_go     (line_go)
   );

   still_disp_addr_calc #(
      .ADDR_W     (ADDR_W),
      .STRIDE_W   (STRIDE_W),
      .READS_W    (READS_W),
      .LINE_W     (LINE_W),
      .CHROMA_420 (CHROMA_420)
   ) u_addr_calc (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_go     (line_go),
      .line_idx    (line_idx),
      .parity      (sh_parity),
      .stride      (sh_stride),
      .luma_base   (sh_luma_base),
      .chroma_base (sh_chroma_base),
      .reads       (sh_reads),
      .luma_addr   (luma_addr),
      .chroma_addr (chroma_addr),
      .line_reads  (line_reads),
      .addr_valid  (addr_valid)
   );

   still_disp_dec_gate u_dec_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .dec_started (dec_started),
      .freeze      (freeze),
      .dec_req     (dec_req)
   );
endmodule

// File: rtl/still_disp_addr_chk.sv
module still_disp_addr_chk #(
   parameter int unsigned READS_W = 8
)(
   input logic               clk,
   input logic               rst_n,
   input logic               field_start,
   input logic               line_start,
   input logic               dec_started,
   input logic               freeze,
   input logic               addr_valid,
   input logic               dec_req,
   input logic [READS_W-1:0] line_reads
);
   // R2: a line strobe alone yields valid addresses next cycle
   p_valid_after_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !field_start) |=> addr_valid);

   // R2: no valid without a preceding line strobe
   p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_start && !field_start) |=> !addr_valid);

   // R11: decode request follows an ungated field strobe
   p_req_on_field_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && dec_started && !freeze) |=> dec_req);

   // R11: freeze, stopped decoder or no field strobe suppress the request
   p_req_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!field_start || freeze || !dec_started) |=> !dec_req);

   // R9: read count only moves after a line strobe
   p_reads_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_start && !field_start) |=> $stable(line_reads));
endmodule

bind still_disp_addr still_disp_addr_chk #(.READS_W(READS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .field_start (field_start),
   .line_start  (line_start),
   .dec_started (dec_started),
   .freeze      (freeze),
   .addr_valid  (addr_valid),
   .dec_req     (dec_req),
   .line_reads  (line_reads)
);

// File: tb/still_disp_addr_tb.sv
`timescale 1ns/1ps
module still_disp_addr_tb;
   localparam int AW = 24;
   localparam int WW = 8;
   localparam int RW = 8;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          field_start = 1'b0, line_start = 1'b0, field_par = 1'b0;
   logic          ovr_en = 1'b0, field_mode = 1'b0, top_first = 1'b1;
   logic [AW-1:0] ovr_luma_base = '0, ovr_chroma_base = '0;
   logic [WW-1:0] pic_width = '0;
   logic [RW-1:0] reads_per_line = '0;
   logic [AW-1:0] dec_luma_base = '0, dec_chroma_base = '0;
   logic          dec_started = 1'b0, freeze = 1'b0;
   logic [AW-1:0] luma_addr, chroma_addr;
   logic [RW-1:0] line_reads;
   logic          addr_valid, dec_req;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   still_disp_addr #(.ADDR_W(AW), .WIDTH_W(WW), .READS_W(RW), .LINE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
      .field_par(field_par), .ovr_en(ovr_en), .field_mode(field_mode),
      .top_first(top_first), .ovr_luma_base(ovr_luma_base),
      .ovr_chroma_base(ovr_chroma_base), .pic_width(pic_width),
      .reads_per_line(reads_per_line), .dec_luma_base(dec_luma_base),
      .dec_chroma_base(dec_chroma_base), .dec_started(dec_started),
      .freeze(freeze), .luma_addr(luma_addr), .chroma_addr(chroma_addr),
      .line_reads(line_reads), .addr_valid(addr_valid), .dec_req(dec_req));

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic longint exp_addr(input longint base, input int row, input int w);
      int weff;
      weff = (w == 0) ? 1 : w;
      return (base + longint'(row) * longint'(weff * 8)) & ((64'd1 << AW) - 1);
   endfunction

   // Field strobe; samples dec_req in the following cycle.
   task automatic do_field(input logic par, output logic req_seen);
      @(negedge clk);
      field_par   = par;
      field_start = 1'b1;
      @(negedge clk);
      field_start = 1'b0;
      req_seen    = dec_req;
   endtask

   task automatic do_line();
      @(negedge clk);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic req;
      int   widths[4] = '{0, 1, 5, 255};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 luma", luma_addr, 0);
      chk("R1 chroma", chroma_addr, 0);
      chk("R1 reads", line_reads, 0);
      chk("R1 valid", addr_valid, 0);
      chk("R1 dec_req", dec_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 idle valid", addr_valid, 0);

      // Sweep: override x mode x field order x display parity x width x line
      for (int ov = 0; ov < 2; ov++)
         for (int md = 0; md < 2; md++)
            for (int tf = 0; tf < 2; tf++)
               for (int fp = 0; fp < 2; fp++)
                  for (int wi = 0; wi < 4; wi++) begin
                     int    p;
                     longint lb, cb;
                     string lab;
                     ovr_en          = ov[0];
                     field_mode      = md[0];
                     top_first       = tf[0];
                     pic_width       = WW'(widths[wi]);
                     reads_per_line  = RW'(wi * 3 + 7);
                     ovr_luma_base   = AW'(24'hF00000 + wi * 24'h10);
                     ovr_chroma_base = AW'(24'h180000 + wi * 24'h20);
                     dec_luma_base   = AW'(24'h020000 + wi * 24'h40);
                     dec_chroma_base = AW'(24'h030000 + wi * 24'h80);
                     lb = ov ? ovr_luma_base : dec_luma_base;
                     cb = ov ? ovr_chroma_base : dec_chroma_base;
                     if (!ov)     p = fp;          // R8
                     else if (md) p = tf ? 0 : 1;  // R6
                     else         p = fp ^ (tf ? 0 : 1); // R7
                     if (widths[wi] == 0) lab = "R4 luma";
                     else if (!ov)        lab = "R8 luma";
                     else if (md)         lab = "R3 R6 luma";
                     else                 lab = "R3 R7 luma";
                     do_field(fp[0], req);
                     for (int k = 0; k < 6; k++) begin
                        do_line();
                        chk("R2 valid", addr_valid, 1);
                        chk(lab, luma_addr, exp_addr(lb, 2 * k + p, widths[wi]));
                        chk("R5 chroma", chroma_addr,
                            exp_addr(cb, 2 * (k / 2) + p, widths[wi]));
                        chk("R9 reads", line_reads, wi * 3 + 7);
                        @(negedge clk);
                        chk("R2 valid drop", addr_valid, 0);
                     end
                  end

      // R10: mid-field host writes are held off until the next field
      ovr_en = 1'b1; field_mode = 1'b0; top_first = 1'b1;
      pic_width = 8'd4; reads_per_line = 8'd20;
      ovr_luma_base = 24'h400000; ovr_chroma_base = 24'h500000;
      do_field(1'b0, req);
      do_line();
      chk("R10 first line", luma_addr, exp_addr(24'h400000, 0, 4));
      pic_width = 8'd9; reads_per_line = 8'd33; ovr_luma_base = 24'h600000;
      field_mode = 1'b1; top_first = 1'b0;
      do_line();
      chk("R10 held luma", luma_addr, exp_addr(24'h400000, 2, 4));
      chk("R10 held reads", line_reads, 20);
      do_field(1'b0, req);
      do_line();
      chk("R10 new luma", luma_addr, exp_addr(24'h600000, 1, 9));
      chk("R10 new reads", line_reads, 33);

      // R11: decode request gating, independent of override
      dec_started = 1'b1; freeze = 1'b0; ovr_en = 1'b1;
      do_field(1'b1, req);
      chk("R11 req under override", req, 1);
      @(negedge clk);
      chk("R11 req one cycle", dec_req, 0);
      ovr_en = 1'b0;
      do_field(1'b0, req);
      chk("R11 req no override", req, 1);
      freeze = 1'b1;
      do_field(1'b1, req);
      chk("R11 freeze suppresses", req, 0);
      do_field(1'b0, req);
      chk("R11 freeze held", req, 0);
      freeze = 1'b0; dec_started = 1'b0;
      do_field(1'b1, req);
      chk("R11 not started", req, 0);
      dec_started = 1'b1;
      do_field(1'b0, req);
      chk("R11 resumes", req, 1);
      do_line();
      chk("R11 no req on line", dec_req, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule